// File: doc/BRIEF.md
# Systematic Rate-1/2 Convolutional Encoder

This block encodes a serial stream of information bits with a systematic convolutional code of rate one half. For every information bit offered with its valid strobe, it produces a pair of code bits. The upper bit of the pair is the information bit itself. The lower bit is the modulo-2 sum of that bit and the bit accepted before it. The encoder keeps one bit of memory, so its trellis has exactly two states. The state index is the most recent accepted information bit, and it is driven on a port so that a neighbouring block can follow the trellis path.

The trellis is held as an enumerated state machine with two states. `ST_S0` means the last accepted bit was 0 and `ST_S1` means it was 1. Every state has two outgoing branches, and four transitions are named:

| Transition | From | Input | Pair | To |
|---|---|---|---|---|
| `stay0` | `ST_S0` | 0 | 00 | `ST_S0` |
| `leave0` | `ST_S0` | 1 | 11 | `ST_S1` |
| `leave1` | `ST_S1` | 0 | 01 | `ST_S0` |
| `stay1` | `ST_S1` | 1 | 10 | `ST_S1` |

The code pair and its strobe are registered, so they appear one cycle after the input is accepted. A synchronous reset returns the trellis to `ST_S0`, so every encoded stream starts from the zero state.

Top module: `conv_sys_enc`

## Requirements
- R1: While `rst` is high at a clock edge, the state returns to 0, `code_valid` goes to 0 and `code_bits` goes to 00, whatever `in_valid` and `in_bit` carry.
- R2: `code_valid` is 1 in exactly those cycles that follow a clock edge at which `in_valid` was 1 outside reset.
- R3: When `code_valid` is 1, `code_bits[1]` (the systematic bit) equals the information bit that was accepted one cycle earlier.
- R4: When `code_valid` is 1, `code_bits[0]` (the parity bit) equals the XOR of the accepted bit and the state index that was present when that bit was accepted.
- R5: After an accepted input, `state_idx` equals that input bit (0 for `ST_S0`, 1 for `ST_S1`).
- R6: A clock edge with `in_valid` low changes neither `state_idx` nor `code_bits`.
- R7: Starting from reset, the accepted bits 1,1,0,0,1,1 yield the pairs 11,10,01,00,11,10, where the pair is written as {`code_bits[1]`,`code_bits[0]`}.
- R8: All four branches behave as the transition table shows: `stay0` gives 00, `leave0` gives 11, `leave1` gives 01 and `stay1` gives 10, and each branch ends in the state listed for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Information bit |
| in_valid | input | 1 | `in_bit` is accepted at this edge |
| code_bits | output | 2 | Code pair, bit 1 systematic, bit 0 parity |
| code_valid | output | 1 | `code_bits` holds a fresh pair this cycle |
| state_idx | output | 1 | Current trellis state index (last accepted bit) |

## Verification
The assertions assume that `in_bit` and `in_valid` are known (not X) at every clock edge after reset. They also assume that reset lasts at least one edge, so the first sampled history is a reset cycle. The bench drives both inputs on the falling edge with defined values throughout, including during reset, where it deliberately offers valid bits that must be ignored. Idle cycles are interleaved with accepted bits, so the hold behaviour is exercised from both states.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;

    // Memory depth of the encoder; the trellis below is written for one register
    localparam int MEM_DEPTH = 1;
    localparam int STATE_W   = MEM_DEPTH;
    localparam int CODE_W    = 2;
    localparam int NUM_STATES = 1 << MEM_DEPTH;

    // Trellis states: index equals the previous accepted information bit
    typedef enum logic [STATE_W-1:0] {
        ST_S0 = 1'b0,
        ST_S1 = 1'b1
    } enc_state_e;

    // Code pair: systematic bit sits in the upper position
    typedef struct packed {
        logic sys;
        logic par;
    } code_pair_t;

endpackage

// File: rtl/conv_enc_branch.sv
module conv_enc_branch
    import conv_enc_pkg::*;
(
    input  enc_state_e cur_state,
    input  logic       info_bit,
    output enc_state_e nxt_state,
    output code_pair_t pair
);

    // Branch selection: one case arm per trellis state, two branches each
    always_comb begin
        nxt_state = ST_S0;
        pair      = '0;
        unique case (cur_state)
            ST_S0: begin
                // stay0: 0 -> pair 00 ; leave0: 1 -> pair 11
                nxt_state = info_bit ? ST_S1 : ST_S0;
                pair.sys  = info_bit;
                pair.par  = info_bit;
            end
            ST_S1: begin
                // leave1: 0 -> pair 01 ; stay1: 1 -> pair 10
                nxt_state = info_bit ? ST_S1 : ST_S0;
                pair.sys  = info_bit;
                pair.par  = ~info_bit;
            end
            default: begin
                nxt_state = ST_S0;
                pair      = '0;
            end
        endcase
    end

endmodule

// File: rtl/conv_enc_state_reg.sv
module conv_enc_state_reg
    import conv_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  enc_state_e d_state,
    output enc_state_e q_state
);

    // State register: advances only on accepted inputs
    always_ff @(posedge clk) begin
        if (rst) begin
            q_state <= ST_S0;
        end else if (load) begin
            q_state <= d_state;
        end
    end

endmodule

// File: rtl/conv_enc_out_reg.sv
module conv_enc_out_reg
    import conv_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  code_pair_t        pair_in,
    output logic [CODE_W-1:0] code_bits,
    output logic              code_valid
);

    // Output process: registers the pair and its strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            code_bits  <= '0;
            code_valid <= 1'b0;
        end else begin
            code_valid <= load;
            if (load) begin
                code_bits <= pair_in;
            end
        end
    end

endmodule

// File: rtl/conv_sys_enc.sv
module conv_sys_enc
    import conv_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_bit,
    input  logic              in_valid,
    output logic [CODE_W-1:0] code_bits,
    output logic              code_valid,
    output logic [STATE_W-1:0] state_idx
);

    enc_state_e cur_state;
    enc_state_e nxt_state;
    code_pair_t pair;

    conv_enc_branch u_branch (
        .cur_state (cur_state),
        .info_bit  (in_bit),
        .nxt_state (nxt_state),
        .pair      (pair)
    );

    conv_enc_state_reg u_state (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .d_state (nxt_state),
        .q_state (cur_state)
    );

    conv_enc_out_reg u_out (
        .clk        (clk),
        .rst        (rst),
        .load       (in_valid),
        .pair_in    (pair),
        .code_bits  (code_bits),
        .code_valid (code_valid)
    );

    assign state_idx = cur_state;

endmodule

// File: rtl/conv_sys_enc_checker.sv
module conv_sys_enc_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_bit,
    input logic       in_valid,
    input logic [1:0] code_bits,
    input logic       code_valid,
    input logic [0:0] state_idx
);

    // R1: after a reset edge the trellis sits in state 0 with no output
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (state_idx == 1'b0 && code_valid == 1'b0 && code_bits == 2'b00));

    // R2: strobe follows an accepted input by one cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (code_valid == $past(in_valid)));

    // R3: systematic bit equals the accepted bit
    a_r3_systematic: assert property (@(posedge clk) disable iff (rst)
        (code_valid && !$past(rst)) |-> (code_bits[1] == $past(in_bit)));

    // R4: parity bit combines accepted bit with the prior state
    a_r4_parity: assert property (@(posedge clk) disable iff (rst)
        (code_valid && !$past(rst)) |-> (code_bits[0] == ($past(in_bit) ^ $past(state_idx[0]))));

    // R5: state tracks the last accepted bit
    a_r5_state_tracks: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid)) |-> (state_idx[0] == $past(in_bit)));

    // R6: idle edges leave state and code pair alone
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> ($stable(state_idx) && $stable(code_bits)));

endmodule

bind conv_sys_enc conv_sys_enc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_bit     (in_bit),
    .in_valid   (in_valid),
    .code_bits  (code_bits),
    .code_valid (code_valid),
    .state_idx  (state_idx)
);

// File: tb/sim_conv_sys_enc.sv
module sim_conv_sys_enc;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_bit = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] code_bits;
    logic       code_valid;
    logic [0:0] state_idx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Bench model of the trellis
    logic       m_state = 1'b0;
    logic [1:0] m_code  = 2'b00;

    conv_sys_enc u0 (
        .clk        (clk),
        .rst        (rst),
        .in_bit     (in_bit),
        .in_valid   (in_valid),
        .code_bits  (code_bits),
        .code_valid (code_valid),
        .state_idx  (state_idx)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check at the next falling edge
    task automatic step(input logic b, input logic v, input string req);
        logic exp_cv;
        in_bit   = b;
        in_valid = v;
        @(negedge clk);
        if (v) begin
            m_code  = {b, b ^ m_state};
            m_state = b;
        end
        exp_cv = v;
        check(code_valid == exp_cv, {req, " R2 strobe"}, int'(code_valid), int'(exp_cv));
        check(code_bits == m_code, {req, " R3/R4 pair"}, int'(code_bits), int'(m_code));
        check(state_idx[0] == m_state, {req, " R5/R6 state"}, int'(state_idx), int'(m_state));
    endtask

    task automatic do_reset();
        rst      = 1'b1;
        in_valid = 1'b1;
        in_bit   = 1'b1;
        @(negedge clk);
        @(negedge clk);
        m_state = 1'b0;
        m_code  = 2'b00;
        // R1: reset wins over a valid input
        check(state_idx == 1'b0, "R1 state", int'(state_idx), 0);
        check(code_valid == 1'b0, "R1 valid", int'(code_valid), 0);
        check(code_bits == 2'b00, "R1 code", int'(code_bits), 0);
        rst      = 1'b0;
        in_valid = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (!done && cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R7: reference sequence from state 0
        begin
            logic [1:0] ref_pairs [6];
            logic       ref_bits  [6];
            ref_bits  = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
            ref_pairs = '{2'b11, 2'b10, 2'b01, 2'b00, 2'b11, 2'b10};
            for (int k = 0; k < 6; k++) begin
                step(ref_bits[k], 1'b1, "R7");
                check(code_bits == ref_pairs[k], "R7 literal pair", int'(code_bits), int'(ref_pairs[k]));
            end
        end

        // R8: every branch from every state, literal pairs
        for (int s = 0; s < 2; s++) begin
            for (int b = 0; b < 2; b++) begin
                logic [1:0] lit;
                do_reset();
                if (s == 1) step(1'b1, 1'b1, "R8 setup");
                step(1'(b), 1'b1, "R8");
                lit = (s == 0) ? (b == 0 ? 2'b00 : 2'b11) : (b == 0 ? 2'b01 : 2'b10);
                check(code_bits == lit, "R8 branch pair", int'(code_bits), int'(lit));
                check(state_idx[0] == 1'(b), "R8 branch target", int'(state_idx), b);
            end
        end

        // R6: idle cycles from both states
        do_reset();
        step(1'b1, 1'b1, "R6 setup");
        step(1'b0, 1'b0, "R6 idle S1");
        step(1'b1, 1'b0, "R6 idle S1");
        step(1'b0, 1'b1, "R6 setup");
        step(1'b1, 1'b0, "R6 idle S0");

        // Exhaustive sweep over all sequences up to six bits, with idle gaps
        for (int len = 1; len <= 6; len++) begin
            for (int pat = 0; pat < (1 << len); pat++) begin
                for (int k = 0; k < len; k++) begin
                    step(1'(pat >> k), 1'b1, "R3 R4 R5 sweep");
                    if (((pat + k) % 3) == 0) step(1'(~(pat >> k)), 1'b0, "R6 sweep idle");
                end
            end
        end

        // R1: reset in the middle of a stream from state 1
        step(1'b1, 1'b1, "R1 setup");
        do_reset();
        step(1'b0, 1'b1, "R1 restart");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule